// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects request pulses from a parameterized set of interrupt sources and decides when a processor core should be interrupted, and for which source. Each source has an enable, a sticky pending flag, a group priority (0 to 7) and a subgroup priority (0 to 3). Only the group priority can interrupt work that is already running. The subgroup priority, and after it the source index, only decide which of several waiting requests is served first.

The controller keeps the priority level the core is running at, plus a small stack of the levels that were interrupted. When the core accepts a request, the current level is saved and the level rises to the group of the granted source. When the core returns, the saved level comes back. Requests at group 0 are never raised, and a global enable can hold back all requests without losing any pending flags.

Pending flags are never cleared by the handshake. Software clears them with explicit strobes, and it can also set them to force an interrupt.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A pending flag is set by a source pulse or a software set strobe, and stays set until its clear strobe is applied. When a set and a clear hit the same source in the same cycle, the flag ends up set. `pend_o[i]` shows the flag of source i.
- R2: A source whose enable bit is 0, or whose group priority is 0, never causes `core_req`, even while its pending flag is set.
- R3: After reset the running level is 0 and the level stack is empty. `core_req` is high only when the winning pending source has a group priority strictly greater than the running level. A winner at the same group as the running level waits.
- R4: Among eligible pending sources, the one with the highest group priority wins. `core_vec` gives its index and `core_lvl` gives its group.
- R5: Among eligible pending sources of equal group, the one with the higher subgroup priority wins.
- R6: When group and subgroup are both equal, the lowest source index wins. Waiting requests compete in the same way, however long they have been pending.
- R7: When `core_ack` is high in a cycle where `core_req` is high, the running level is pushed and, from the next cycle, `run_lvl` equals the granted group. An acknowledge while `core_req` is low has no effect.
- R8: When `core_rfi` is high, the most recently pushed level is restored on the next cycle. A return with an empty stack leaves `run_lvl` at 0. When a return and an acknowledge arrive in the same cycle, only the return takes effect.
- R9: While `glob_en` is 0, `core_req` stays low and pending flags are kept. Once `glob_en` is 1 again, the request is raised with no new pulse.
- R10: Nesting reaches `STACK_DEPTH` (default 7) levels. Each nested grant raises the level by at least one, and returns unwind the levels in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NUM_SRC | Request pulses from the sources |
| sw_set | input | NUM_SRC | Software strobes that force pending flags |
| clr_strobe | input | NUM_SRC | Strobes that clear pending flags |
| src_en | input | NUM_SRC | Enable bit of each source |
| src_grp | input | 3*NUM_SRC | Group priority, source i at bits [3i+2:3i] |
| src_sub | input | 2*NUM_SRC | Subgroup priority, source i at bits [2i+1:2i] |
| glob_en | input | 1 | Global request enable |
| core_req | output | 1 | Request to the core to preempt |
| core_vec | output | ID_W | Index of the winning source |
| core_lvl | output | 3 | Group priority of the winning source |
| core_ack | input | 1 | Core accepts the current request |
| core_rfi | input | 1 | Core returns from the current service |
| run_lvl | output | 3 | Priority level currently running |
| pend_o | output | NUM_SRC | Pending flags |

## Verification
The bench builds the block with eight sources and a stack depth of seven. With these values every group level from 1 to 7 can be nested at once, so the stack can be filled completely and unwound all the way. Eight sources are enough to set up three-way ties on group and subgroup, so the order by index is tested. A long random phase changes the configuration, pulses and handshakes together, which produces returns at the base level, acknowledges while nothing is requested, and collisions between set and clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int GRP_W = 3;
  localparam int SUB_W = 2;
  localparam int KEY_W = GRP_W + SUB_W;

  typedef logic [GRP_W-1:0] grp_t;
  typedef logic [SUB_W-1:0] sub_t;
  typedef logic [KEY_W-1:0] key_t;

  // Ordering key: group in the upper bits, subgroup in the lower bits.
  function automatic key_t rank_key(grp_t g, sub_t s);
    return {g, s};
  endfunction

  // Strictly better: equal keys do not displace an earlier (lower index) holder.
  function automatic logic key_beats(key_t cand, key_t held);
    return cand > held;
  endfunction

  function automatic grp_t key_group(key_t k);
    return k[KEY_W-1:SUB_W];
  endfunction
endpackage

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 3
) (
  input  logic [NUM_SRC-1:0]       elig_i,
  input  logic [NUM_SRC*GRP_W-1:0] grp_i,
  input  logic [NUM_SRC*SUB_W-1:0] sub_i,
  output logic                     win_valid_o,
  output logic [ID_W-1:0]          win_id_o,
  output grp_t                     win_grp_o
);
  key_t best_key;
  key_t cand;

  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    best_key    = '0;
    cand        = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      cand = rank_key(grp_i[i*GRP_W +: GRP_W], sub_i[i*SUB_W +: SUB_W]);
      if (elig_i[i] && (!win_valid_o || key_beats(cand, best_key))) begin
        win_valid_o = 1'b1;
        win_id_o    = ID_W'(i);
        best_key    = cand;
      end
    end
  end

  assign win_grp_o = key_group(best_key);
endmodule

// File: rtl/irqc_level_stack.sv
module irqc_level_stack
  import irqc_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int SP_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  grp_t            push_lvl_i,
  output grp_t            cur_lvl_o,
  output logic [SP_W-1:0] depth_o
);
  localparam int IDX_W = $clog2(DEPTH);

  grp_t saved [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lvl_o <= '0;
      depth_o   <= '0;
    end else if (pop_i && depth_o != '0) begin
      cur_lvl_o <= saved[IDX_W'(depth_o - 1'b1)];
      depth_o   <= depth_o - 1'b1;
    end else if (push_i && depth_o != SP_W'(DEPTH)) begin
      saved[IDX_W'(depth_o)] <= cur_lvl_o;
      cur_lvl_o              <= push_lvl_i;
      depth_o                <= depth_o + 1'b1;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 7,
  localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_pulse,
  input  logic [NUM_SRC-1:0]       sw_set,
  input  logic [NUM_SRC-1:0]       clr_strobe,
  input  logic [NUM_SRC-1:0]       src_en,
  input  logic [NUM_SRC*GRP_W-1:0] src_grp,
  input  logic [NUM_SRC*SUB_W-1:0] src_sub,
  input  logic                     glob_en,
  output logic                     core_req,
  output logic [ID_W-1:0]          core_vec,
  output logic [GRP_W-1:0]         core_lvl,
  input  logic                     core_ack,
  input  logic                     core_rfi,
  output logic [GRP_W-1:0]         run_lvl,
  output logic [NUM_SRC-1:0]       pend_o
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);

  logic [NUM_SRC-1:0] elig;
  logic               win_valid;
  logic [ID_W-1:0]    win_id;
  grp_t               win_grp;
  logic [SP_W-1:0]    stk_depth;
  logic               stk_full;
  logic               grant_fire;
  logic               ret_fire;

  irqc_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_i(src_pulse | sw_set), .clr_i(clr_strobe), .flag_o(pend_o)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = pend_o[i] & src_en[i] & (src_grp[i*GRP_W +: GRP_W] != '0);
  end

  irqc_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .elig_i(elig), .grp_i(src_grp), .sub_i(src_sub),
    .win_valid_o(win_valid), .win_id_o(win_id), .win_grp_o(win_grp)
  );

  assign stk_full   = (stk_depth == SP_W'(STACK_DEPTH));
  assign core_req   = glob_en & win_valid & (win_grp > run_lvl) & ~stk_full;
  assign core_vec   = win_id;
  assign core_lvl   = win_grp;
  assign grant_fire = core_ack & core_req & ~core_rfi;
  assign ret_fire   = core_rfi & (stk_depth != '0);

  irqc_level_stack #(.DEPTH(STACK_DEPTH), .SP_W(SP_W)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push_i(grant_fire), .pop_i(ret_fire), .push_lvl_i(win_grp),
    .cur_lvl_o(run_lvl), .depth_o(stk_depth)
  );
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 7,
  parameter int SP_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glob_en,
  input logic               core_req,
  input logic [2:0]         core_lvl,
  input logic               core_rfi,
  input logic [2:0]         run_lvl,
  input logic [NUM_SRC-1:0] pend_o,
  input logic [NUM_SRC-1:0] clr_strobe,
  input logic [SP_W-1:0]    stk_depth,
  input logic               grant_fire,
  input logic               ret_fire
);
  p_pend_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

  p_no_grp0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> (core_lvl != 3'd0));

  p_req_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> (core_lvl > run_lvl));

  p_grant_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> (run_lvl == $past(core_lvl)));

  p_base_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rfi && stk_depth == '0) |=> (run_lvl == 3'd0));

  p_return_lowers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (run_lvl < $past(run_lvl)));

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !core_req);

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= SP_W'(DEPTH));
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .DEPTH(STACK_DEPTH), .SP_W(SP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .core_req(core_req),
  .core_lvl(core_lvl), .core_rfi(core_rfi), .run_lvl(run_lvl),
  .pend_o(pend_o), .clr_strobe(clr_strobe), .stk_depth(stk_depth),
  .grant_fire(grant_fire), .ret_fire(ret_fire)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;
  localparam int N = 8;
  localparam int D = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_pulse = '0, sw_set = '0, clr_strobe = '0, src_en = '0;
  logic [3*N-1:0] src_grp;
  logic [2*N-1:0] src_sub;
  logic glob_en = 1'b0, core_ack = 1'b0, core_rfi = 1'b0;
  logic core_req;
  logic [2:0] core_vec, core_lvl, run_lvl;
  logic [N-1:0] pend_o;

  int c_grp [N];
  int c_sub [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      src_grp[3*i +: 3] = 3'(c_grp[i]);
      src_sub[2*i +: 2] = 2'(c_sub[i]);
    end
  end

  always #2.5 clk = ~clk;

  nest_irq_ctrl #(.NUM_SRC(N), .STACK_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .sw_set(sw_set),
    .clr_strobe(clr_strobe), .src_en(src_en), .src_grp(src_grp),
    .src_sub(src_sub), .glob_en(glob_en), .core_req(core_req),
    .core_vec(core_vec), .core_lvl(core_lvl), .core_ack(core_ack),
    .core_rfi(core_rfi), .run_lvl(run_lvl), .pend_o(pend_o)
  );

  // Reference model state
  logic [N-1:0] m_pend = '0;
  int m_run = 0;
  int m_stack [$];
  int total = 0, fails = 0;
  string phase = "R3 reset";

  task automatic check(string what, int got, int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL [%s] %s: got %0d expected %0d", phase, what, got, exp);
    end
  endtask

  // Winner: scan from the top index down, equal keys move toward lower index.
  function automatic int find_winner();
    int best = -1;
    int best_key = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_pend[i] && src_en[i] && c_grp[i] != 0 && (c_grp[i] * 4 + c_sub[i]) >= best_key) begin
        best = i;
        best_key = c_grp[i] * 4 + c_sub[i];
      end
    end
    return best;
  endfunction

  task automatic tick();
    int w;
    bit exp_req;
    #1;
    w = find_winner();
    exp_req = glob_en && (w >= 0) && (c_grp[w] > m_run) && (m_stack.size() < D);
    check("pending flags", int'(pend_o), int'(m_pend));
    check("request", int'(core_req), int'(exp_req));
    check("running level", int'(run_lvl), m_run);
    if (exp_req) begin
      check("vector", int'(core_vec), w);
      check("granted group", int'(core_lvl), c_grp[w]);
    end
    for (int i = 0; i < N; i++) begin
      if (src_pulse[i] || sw_set[i]) m_pend[i] = 1'b1;
      else if (clr_strobe[i])        m_pend[i] = 1'b0;
    end
    if (core_rfi) begin
      if (m_stack.size() > 0) m_run = m_stack.pop_back();
    end else if (core_ack && exp_req) begin
      m_stack.push_back(m_run);
      m_run = c_grp[w];
    end
    @(posedge clk);
    @(negedge clk);
    src_pulse = '0; sw_set = '0; clr_strobe = '0; core_ack = 1'b0; core_rfi = 1'b0;
  endtask

  task automatic cfg(int i, int g, int s, bit e);
    c_grp[i] = g; c_sub[i] = s; src_en[i] = e;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL [watchdog] run did not end: got timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) cfg(i, (i % 7) + 1, 0, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R3 reset state";
    check("run level after reset", int'(run_lvl), 0);
    check("request after reset", int'(core_req), 0);
    idle(2);

    // R1: sticky pending while globally masked
    phase = "R1 sticky pending";
    src_pulse[2] = 1'b1; tick();
    idle(3);
    check("R1 flag held", int'(pend_o[2]), 1);
    clr_strobe[2] = 1'b1; tick();
    phase = "R1 set beats clear";
    src_pulse[5] = 1'b1; clr_strobe[5] = 1'b1; tick();
    check("R1 flag after collision", int'(pend_o[5]), 1);
    sw_set[6] = 1'b1; tick();
    clr_strobe = '1; tick();

    // R2: disabled and group-0 sources never request
    phase = "R2 disabled sources";
    glob_en = 1'b1;
    cfg(0, 0, 3, 1'b1); cfg(1, 5, 0, 1'b0);
    sw_set[0] = 1'b1; sw_set[1] = 1'b1; tick();
    idle(3);
    check("R2 no request", int'(core_req), 0);
    clr_strobe = '1; tick();

    // R5 / R6 / R3 same group waits
    phase = "R5 subgroup order";
    cfg(3, 4, 1, 1'b1); cfg(4, 4, 3, 1'b1); cfg(5, 4, 3, 1'b1);
    sw_set[3] = 1'b1; sw_set[5] = 1'b1; tick();
    check("R5 vector", int'(core_vec), 5);
    phase = "R6 index tie";
    sw_set[4] = 1'b1; tick();
    check("R6 vector", int'(core_vec), 4);
    phase = "R7 grant";
    core_ack = 1'b1; tick();
    check("R7 level raised", int'(run_lvl), 4);
    phase = "R3 same group waits";
    idle(2);
    check("R3 no preempt at equal group", int'(core_req), 0);
    phase = "R7 ack without request";
    core_ack = 1'b1; tick();
    check("R7 level unchanged", int'(run_lvl), 4);
    phase = "R8 return";
    clr_strobe[4] = 1'b1; core_rfi = 1'b1; tick();
    check("R8 level restored", int'(run_lvl), 0);
    check("R6 waiting peer now wins", int'(core_vec), 5);
    clr_strobe = '1; tick();

    // R4: group dominates subgroup
    phase = "R4 group order";
    cfg(2, 2, 3, 1'b1); cfg(6, 6, 0, 1'b1);
    sw_set[2] = 1'b1; sw_set[6] = 1'b1; tick();
    check("R4 vector", int'(core_vec), 6);
    check("R4 level", int'(core_lvl), 6);
    // R8: ack and return together, return only
    phase = "R8 ack with return";
    core_ack = 1'b1; core_rfi = 1'b1; tick();
    check("R8 level stays base", int'(run_lvl), 0);
    // R9 mask
    phase = "R9 global mask";
    glob_en = 1'b0; idle(3);
    check("R9 masked", int'(core_req), 0);
    check("R9 pending kept", int'(pend_o[6]), 1);
    glob_en = 1'b1; tick();
    check("R9 request back", int'(core_req), 1);
    clr_strobe = '1; tick();

    // R10 full nesting
    phase = "R10 nesting";
    for (int i = 0; i < N; i++) cfg(i, (i < 7) ? i + 1 : 7, 0, 1'b1);
    for (int i = 0; i < 7; i++) begin
      sw_set[i] = 1'b1; tick();
      core_ack = 1'b1; tick();
    end
    check("R10 top level", int'(run_lvl), 7);
    sw_set[7] = 1'b1; tick();
    check("R10 no request at top", int'(core_req), 0);
    clr_strobe = '1; tick();
    for (int i = 6; i >= 0; i--) begin
      core_rfi = 1'b1; tick();
      check("R10 unwind", int'(run_lvl), i);
    end
    phase = "R8 return at base";
    core_rfi = 1'b1; tick();
    check("R8 base stays", int'(run_lvl), 0);

    // Random mix
    phase = "R3 R4 R5 R6 R7 R8 random";
    for (int k = 0; k < 3000; k++) begin
      if (k % 200 == 0) begin
        for (int i = 0; i < N; i++)
          cfg(i, int'($urandom % 8), int'($urandom % 4), ($urandom % 5) != 0);
        glob_en = ($urandom % 6) != 0;
      end
      for (int i = 0; i < N; i++) begin
        src_pulse[i]  = ($urandom % 23) == 0;
        sw_set[i]     = ($urandom % 97) == 0;
        clr_strobe[i] = ($urandom % 11) == 0;
      end
      core_ack = ($urandom % 3) == 0;
      core_rfi = ($urandom % 5) == 0;
      tick();
    end

    summary();
    $finish;
  end
endmodule